// File: doc/BRIEF.md
# Interrupt Destination Resolver

This block turns an interrupt command into the set of agents that should receive it. A command carries a destination byte, a physical or logical addressing bit, a two-bit shorthand, the index of the sending agent and a three-bit delivery mode. Each of the N agents supplies its own configuration: an 8-bit identifier, an 8-bit logical address and a 4-bit addressing model. The resolver combines these and produces a target mask with one bit per agent. Bit i of the mask stands for agent i.

The result is registered. It appears together with a single-cycle valid pulse on the clock edge after the command strobe. The mask keeps its value until the next command arrives. Delivering the vector to the agents and any arbitration bookkeeping belong to other blocks.

Control is a two-state machine. In ST_IDLE no result is being presented. The transition IDLE_TO_EMIT happens on a command strobe. In ST_EMIT, `tgt_valid_o` is high. From ST_EMIT, the transition EMIT_TO_IDLE happens when no new strobe is present. The transition EMIT_STAY happens when a further strobe arrives in the same cycle as the current result, so back-to-back commands each yield one valid cycle.

Top module: `idr_resolver`

## Requirements
- R1: After reset, `tgt_valid_o` is 0 and `tgt_mask_o` is all zeros.
- R2: Every cycle with `cmd_valid_i` high is followed, one clock later, by exactly one cycle of `tgt_valid_o` high, even when the resolved mask is empty. `tgt_valid_o` is never high in a cycle that does not follow a strobe.
- R3: Shorthand value 1 selects only the sending agent, the agent whose index equals `cmd_src_i`.
- R4: Shorthand value 2 selects every agent, whatever the destination byte.
- R5: Shorthand value 3 selects every agent except the sender.
- R6: With shorthand 0 and the logical bit at 0, destination 0xFF selects every agent. Any other destination selects the lowest-indexed agent whose identifier equals it, or no agent if none matches.
- R7: With shorthand 0 and the logical bit at 1, an agent whose model is 4'hF is selected when the destination AND its logical address is nonzero.
- R8: With shorthand 0 and the logical bit at 1, an agent whose model is 4'h0 is selected when bits 7:4 of the destination equal bits 7:4 of its logical address, and bits 3:0 of the two share at least one set bit.
- R9: In logical addressing, an agent whose model is neither 4'hF nor 4'h0 is never selected.
- R10: Delivery mode 1 (lowest priority) reduces the mask to its lowest-indexed set bit, and leaves an empty mask empty. Modes 0 fixed, 2 SMI, 4 NMI, 5 INIT, 6 startup and 7 external leave the mask unchanged.
- R11: Back-to-back strobes each yield their own mask on the following cycle. Without a strobe, `tgt_mask_o` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_dest_i | input | 8 | Destination byte |
| cmd_logical_i | input | 1 | 0 = physical addressing, 1 = logical addressing |
| cmd_short_i | input | 2 | Shorthand: 0 destination, 1 self, 2 all, 3 all but self |
| cmd_src_i | input | IDXW | Index of the sending agent (IDXW = clog2 N, 3 by default) |
| cmd_dmode_i | input | 3 | Delivery mode; 1 = lowest priority |
| agent_id_i | input | N*8 | Agent identifiers, agent i in bits 8i+7:8i |
| agent_ldest_i | input | N*8 | Agent logical addresses, agent i in bits 8i+7:8i |
| agent_model_i | input | N*4 | Agent addressing models, agent i in bits 4i+3:4i |
| tgt_valid_o | output | 1 | One-cycle result strobe |
| tgt_mask_o | output | N | Target mask, bit i = agent i |

## Verification
Two things can happen in the same cycle: presenting one result while accepting the next command. The bench provokes this by driving a second strobe in the cycle where the first result is valid. It then checks that the valid output stays high for both cycles and that each cycle shows its own mask, with the second mask appearing exactly one cycle after its strobe. The other pairing is lowest-priority reduction applied to a multi-agent mask from a shorthand or a logical match. Each such vector is judged against the lowest-indexed bit of the mask worked out by hand.

// File: rtl/idr_pkg.sv
package idr_pkg;

    typedef enum logic [1:0] {
        SH_DEST   = 2'd0,
        SH_SELF   = 2'd1,
        SH_ALL    = 2'd2,
        SH_OTHERS = 2'd3
    } short_e;

    typedef enum logic [2:0] {
        DM_FIXED  = 3'd0,
        DM_LOWEST = 3'd1,
        DM_SMI    = 3'd2,
        DM_RSVD   = 3'd3,
        DM_NMI    = 3'd4,
        DM_INIT   = 3'd5,
        DM_START  = 3'd6,
        DM_EXT    = 3'd7
    } dmode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } state_e;

    localparam logic [3:0] MODEL_FLAT    = 4'hF;
    localparam logic [3:0] MODEL_CLUSTER = 4'h0;
    localparam logic [7:0] DEST_BCAST    = 8'hFF;

endpackage

// File: rtl/idr_agent_match.sv
module idr_agent_match #(
    parameter int N = 8
) (
    input  logic [7:0]     dest_i,
    input  logic [N*8-1:0] id_i,
    input  logic [N*8-1:0] ldest_i,
    input  logic [N*4-1:0] model_i,
    output logic [N-1:0]   phys_hit_o,
    output logic [N-1:0]   log_hit_o
);
    import idr_pkg::*;

    for (genvar g = 0; g < N; g++) begin : g_agent
        logic [7:0] agent_id;
        logic [7:0] agent_ld;
        logic [3:0] agent_model;
        logic       flat_hit;
        logic       clus_hit;

        assign agent_id    = id_i[g*8 +: 8];
        assign agent_ld    = ldest_i[g*8 +: 8];
        assign agent_model = model_i[g*4 +: 4];

        // flat model: any shared bit across the whole byte
        assign flat_hit = (agent_model == MODEL_FLAT) && ((dest_i & agent_ld) != 8'h00);
        // cluster model: same cluster number, shared member bit
        assign clus_hit = (agent_model == MODEL_CLUSTER)
                       && (dest_i[7:4] == agent_ld[7:4])
                       && ((dest_i[3:0] & agent_ld[3:0]) != 4'h0);

        assign phys_hit_o[g] = (agent_id == dest_i);
        assign log_hit_o[g]  = flat_hit | clus_hit;
    end

endmodule

// File: rtl/idr_pick_first.sv
module idr_pick_first #(
    parameter int N = 8
) (
    input  logic [N-1:0] vec_i,
    output logic [N-1:0] first_o
);
    // isolate the lowest set bit
    assign first_o = vec_i & (~vec_i + {{(N-1){1'b0}}, 1'b1});

endmodule

// File: rtl/idr_target_build.sv
module idr_target_build #(
    parameter int N = 8,
    localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [7:0]      dest_i,
    input  logic            logical_i,
    input  logic [1:0]      short_i,
    input  logic [IDXW-1:0] src_i,
    input  logic [2:0]      dmode_i,
    input  logic [N*8-1:0]  id_i,
    input  logic [N*8-1:0]  ldest_i,
    input  logic [N*4-1:0]  model_i,
    output logic [N-1:0]    mask_o
);
    import idr_pkg::*;

    logic [N-1:0] phys_hit;
    logic [N-1:0] log_hit;
    logic [N-1:0] phys_first;
    logic [N-1:0] self_vec;
    logic [N-1:0] addr_mask;
    logic [N-1:0] route_mask;
    logic [N-1:0] low_mask;

    idr_agent_match #(.N(N)) u_match (
        .dest_i     (dest_i),
        .id_i       (id_i),
        .ldest_i    (ldest_i),
        .model_i    (model_i),
        .phys_hit_o (phys_hit),
        .log_hit_o  (log_hit)
    );

    idr_pick_first #(.N(N)) u_phys_first (
        .vec_i   (phys_hit),
        .first_o (phys_first)
    );

    for (genvar g = 0; g < N; g++) begin : g_self
        assign self_vec[g] = (src_i == IDXW'(g));
    end

    always_comb begin
        if (logical_i) begin
            addr_mask = log_hit;
        end else if (dest_i == DEST_BCAST) begin
            addr_mask = '1;
        end else begin
            addr_mask = phys_first;
        end
    end

    always_comb begin
        unique case (short_e'(short_i))
            SH_DEST:   route_mask = addr_mask;
            SH_SELF:   route_mask = self_vec;
            SH_ALL:    route_mask = '1;
            SH_OTHERS: route_mask = ~self_vec;
            default:   route_mask = addr_mask;
        endcase
    end

    idr_pick_first #(.N(N)) u_low_first (
        .vec_i   (route_mask),
        .first_o (low_mask)
    );

    assign mask_o = (dmode_e'(dmode_i) == DM_LOWEST) ? low_mask : route_mask;

endmodule

// File: rtl/idr_resolver.sv
module idr_resolver #(
    parameter int N = 8,
    localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid_i,
    input  logic [7:0]      cmd_dest_i,
    input  logic            cmd_logical_i,
    input  logic [1:0]      cmd_short_i,
    input  logic [IDXW-1:0] cmd_src_i,
    input  logic [2:0]      cmd_dmode_i,
    input  logic [N*8-1:0]  agent_id_i,
    input  logic [N*8-1:0]  agent_ldest_i,
    input  logic [N*4-1:0]  agent_model_i,
    output logic            tgt_valid_o,
    output logic [N-1:0]    tgt_mask_o
);
    import idr_pkg::*;

    state_e       state_q;
    state_e       state_d;
    logic [N-1:0] resolved;
    logic [N-1:0] mask_q;

    idr_target_build #(.N(N)) u_build (
        .dest_i    (cmd_dest_i),
        .logical_i (cmd_logical_i),
        .short_i   (cmd_short_i),
        .src_i     (cmd_src_i),
        .dmode_i   (cmd_dmode_i),
        .id_i      (agent_id_i),
        .ldest_i   (agent_ldest_i),
        .model_i   (agent_model_i),
        .mask_o    (resolved)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cmd_valid_i) state_d = ST_EMIT;               // IDLE_TO_EMIT
            ST_EMIT: state_d = cmd_valid_i ? ST_EMIT : ST_IDLE;        // EMIT_STAY / EMIT_TO_IDLE
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (cmd_valid_i) begin
            mask_q <= resolved;
        end
    end

    // outputs
    always_comb begin
        tgt_valid_o = (state_q == ST_EMIT);
        tgt_mask_o  = mask_q;
    end

    AST_PULSE_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_i |=> tgt_valid_o);                                                   // R2
    AST_NO_STRAY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid_i |=> !tgt_valid_o);                                                 // R2
    AST_SELF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_short_i == 2'd1) |=> (tgt_mask_o == (N'(1) << $past(cmd_src_i)))); // R3
    AST_ALL_AGENTS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_short_i == 2'd2 && cmd_dmode_i != 3'd1) |=> (&tgt_mask_o)); // R4
    AST_SKIP_SENDER: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_short_i == 2'd3) |=> ((tgt_mask_o & (N'(1) << $past(cmd_src_i))) == '0)); // R5
    AST_PHYS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_short_i == 2'd0 && !cmd_logical_i && cmd_dest_i != 8'hFF)
        |=> $onehot0(tgt_mask_o));                                                      // R6
    AST_LOWEST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_dmode_i == 3'd1) |=> $onehot0(tgt_mask_o));                 // R10
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid_i |=> $stable(tgt_mask_o));                                          // R11

endmodule

// File: tb/sim_idr_resolver.sv
`timescale 1ns/1ps
module sim_idr_resolver;

    localparam int N = 8;
    localparam int NV = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_dest = 8'h00;
    logic        cmd_logical = 1'b0;
    logic [1:0]  cmd_short = 2'd0;
    logic [2:0]  cmd_src = 3'd0;
    logic [2:0]  cmd_dmode = 3'd0;
    logic [N*8-1:0] agent_id;
    logic [N*8-1:0] agent_ldest;
    logic [N*4-1:0] agent_model;
    logic        tgt_valid;
    logic [N-1:0] tgt_mask;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    // agent 7 .. agent 0; agents 3 and 7 share ID 0x13; agent 6 has model 5
    assign agent_id    = {8'h13, 8'h16, 8'h15, 8'h14, 8'h13, 8'h12, 8'h11, 8'h10};
    assign agent_ldest = {8'h80, 8'h08, 8'h31, 8'h23, 8'h21, 8'h04, 8'h02, 8'h01};
    assign agent_model = {4'hF, 4'h5, 4'h0, 4'h0, 4'h0, 4'hF, 4'hF, 4'hF};

    idr_resolver #(.N(N)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_valid_i   (cmd_valid),
        .cmd_dest_i    (cmd_dest),
        .cmd_logical_i (cmd_logical),
        .cmd_short_i   (cmd_short),
        .cmd_src_i     (cmd_src),
        .cmd_dmode_i   (cmd_dmode),
        .agent_id_i    (agent_id),
        .agent_ldest_i (agent_ldest),
        .agent_model_i (agent_model),
        .tgt_valid_o   (tgt_valid),
        .tgt_mask_o    (tgt_mask)
    );

    // {dest, logical, short, src, dmode, expected mask}
    localparam logic [24:0] VECS [NV] = '{
        {8'h12, 1'b0, 2'd0, 3'd0, 3'd0, 8'h04}, // R6 id match
        {8'h13, 1'b0, 2'd0, 3'd0, 3'd0, 8'h08}, // R6 duplicate id, lowest index
        {8'hFF, 1'b0, 2'd0, 3'd0, 3'd0, 8'hFF}, // R6 broadcast
        {8'h55, 1'b0, 2'd0, 3'd0, 3'd0, 8'h00}, // R6 no match, R2 empty
        {8'h03, 1'b1, 2'd0, 3'd0, 3'd0, 8'h03}, // R7 flat
        {8'h88, 1'b1, 2'd0, 3'd0, 3'd0, 8'h80}, // R9 model 5 skipped, R7
        {8'h21, 1'b1, 2'd0, 3'd0, 3'd0, 8'h19}, // R8 cluster plus R7 flat
        {8'h22, 1'b1, 2'd0, 3'd0, 3'd0, 8'h12}, // R8 member bits
        {8'h31, 1'b1, 2'd0, 3'd0, 3'd1, 8'h01}, // R10 on logical
        {8'h22, 1'b1, 2'd0, 3'd0, 3'd1, 8'h02}, // R10 on logical
        {8'h00, 1'b0, 2'd1, 3'd5, 3'd0, 8'h20}, // R3 self
        {8'h55, 1'b0, 2'd2, 3'd3, 3'd0, 8'hFF}, // R4 all, dest ignored
        {8'h00, 1'b0, 2'd3, 3'd0, 3'd0, 8'hFE}, // R5 others
        {8'h00, 1'b0, 2'd3, 3'd7, 3'd1, 8'h01}, // R5 with R10
        {8'h00, 1'b0, 2'd3, 3'd0, 3'd1, 8'h02}, // R5 with R10
        {8'hFF, 1'b0, 2'd0, 3'd0, 3'd1, 8'h01}, // R10 on broadcast
        {8'h55, 1'b0, 2'd0, 3'd0, 3'd1, 8'h00}, // R10 empty stays empty
        {8'h00, 1'b0, 2'd1, 3'd2, 3'd5, 8'h04}, // R3 with INIT, R10 unchanged
        {8'h88, 1'b1, 2'd0, 3'd0, 3'd7, 8'h80}, // R10 external unchanged
        {8'h00, 1'b1, 2'd0, 3'd0, 3'd0, 8'h00}  // R7 R8 no logical match
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [24:0] v);
        cmd_dest    = v[24:17];
        cmd_logical = v[16];
        cmd_short   = v[15:14];
        cmd_src     = v[13:11];
        cmd_dmode   = v[10:8];
        cmd_valid   = 1'b1;
    endtask

    initial begin
        #400000;
        fails++;
        tests++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 valid", 32'(tgt_valid), 32'd0);
        check("R1 mask", 32'(tgt_mask), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 no strobe no valid", 32'(tgt_valid), 32'd0);

        for (int k = 0; k < NV; k++) begin
            drive(VECS[k]);
            @(negedge clk);
            cmd_valid = 1'b0;
            check($sformatf("R2 valid entry %0d", k), 32'(tgt_valid), 32'd1);
            check($sformatf("R3 R4 R5 R6 R7 R8 R9 R10 mask entry %0d", k),
                  32'(tgt_mask), 32'(VECS[k][7:0]));
            @(negedge clk);
            check($sformatf("R2 single pulse entry %0d", k), 32'(tgt_valid), 32'd0);
            check($sformatf("R11 hold entry %0d", k), 32'(tgt_mask), 32'(VECS[k][7:0]));
        end

        // back-to-back: result of A presented while B is accepted (R11)
        drive(VECS[2]);
        @(negedge clk);
        drive(VECS[10]);
        check("R11 b2b first valid", 32'(tgt_valid), 32'd1);
        check("R11 b2b first mask", 32'(tgt_mask), 32'h000000FF);
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R11 b2b second valid", 32'(tgt_valid), 32'd1);
        check("R11 b2b second mask", 32'(tgt_mask), 32'h00000020);
        @(negedge clk);
        check("R2 b2b ends", 32'(tgt_valid), 32'd0);

        // reset mid-run clears the result
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mask", 32'(tgt_mask), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule